// File: doc/BRIEF.md
# CRC Fingerprint Redundancy Checker

This block confirms that two copies of a critical task, run at different times on different cores, produced the same result. Each core owns a CRC-16 engine. While a core runs a critical copy, the surrounding logic raises that core's `fp_en` and presents one 32-bit event word per cycle: a register write value, store data, or a load/store address. The engine folds each enabled word into a running fingerprint. Non-critical work on the same core keeps `fp_en` low, so its words do not reach the fingerprint.

A task is first registered with `alloc_valid`/`alloc_tid`. This claims one of four slots in a fingerprint store. If no slot is free, the claim is refused and `alloc_full` pulses. When a core finishes a copy, it pulses `done_valid` with its core number and the task ID. The core's fingerprint is written into that task's slot together with an even-parity bit, and the core's engine is reseeded.

Each slot moves through these phases:
- FREE goes to WAIT0 on allocation.
- WAIT0 goes to WAIT1 on the first copy.
- WAIT1 goes to PAIR on the second copy.

A two-state judge (IDLE, JUDGE) selects the lowest-numbered pending slot in IDLE and rules on it in JUDGE.

For a slot in PAIR:
- If the two fingerprints are equal, the judge pulses `release_valid` and the slot returns to FREE.
- Otherwise it pulses `retry_valid` and the slot moves to RETRY, where it waits for a third copy from another core.

That third copy moves the slot to TRIO. The judge then votes the third fingerprint against the two stored ones:
- If it matches exactly one of them, the judge releases the task and names the core of the other copy on `fault_core`.
- If it matches neither, the judge raises `fatal_valid`.

After the vote the slot goes back to FREE. A stored fingerprint whose parity does not check counts as not matching anything.

Top module: `fp_redundancy_checker`

## Requirements
- R1: Each core's fingerprint starts at 0xFFFF. On every cycle with `fp_en` high, it folds in that core's 32-bit word, bit 31 first, using polynomial 0x1021. A `done_valid` for that core captures the fingerprint and reseeds the engine. Copies with identical enabled word streams match. A single flipped bit, or two swapped words, gives a mismatch.
- R2: Words presented while `fp_en` is low have no effect on the fingerprint.
- R3: An allocation is accepted while any slot is free. With all four slots in use, `alloc_full` is high on the cycle after the request, and the task ID is not registered, so its copies are ignored.
- R4: A `done_valid` whose task ID has no slot in WAIT0, WAIT1 or RETRY produces no result output.
- R5: Two matching copies give exactly one `release_valid` pulse carrying the task ID. The slot is then free for a new allocation.
- R6: Two differing copies give one `retry_valid` pulse carrying the task ID, and no release.
- R7: If the third fingerprint matches exactly one stored copy, `release_valid` and `fault_valid` pulse together. `fault_core` names the core of the other stored copy.
- R8: If the third fingerprint matches neither stored copy, `fatal_valid` pulses with the task ID, and there is no release and no fault.
- R9: Out of reset all result outputs are low. Each result is a single-cycle pulse that appears two clock edges after the edge that samples the completing `done_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_en | input | NUM_CORES | Per core: fold this cycle's word (critical copy running) |
| evt_word | input | NUM_CORES*32 | Per core event word, core i at bits [32i+31:32i] |
| done_valid | input | 1 | A core finished a critical copy |
| done_core | input | 2 | Core that finished |
| done_tid | input | 4 | Task ID of the finished copy |
| alloc_valid | input | 1 | Register a new critical task |
| alloc_tid | input | 4 | Task ID to register |
| alloc_full | output | 1 | Previous allocation refused, no free slot |
| release_valid | output | 1 | Task output may be committed |
| release_tid | output | 4 | Task being released |
| retry_valid | output | 1 | Third execution requested |
| retry_tid | output | 4 | Task needing a third execution |
| fault_valid | output | 1 | A faulty core was identified |
| fault_core | output | 2 | Identified faulty core |
| fatal_valid | output | 1 | Vote failed, unrecoverable |
| fatal_tid | output | 4 | Task that failed the vote |

## Verification
The bench targets these corner cases:
- **Single flipped bit and two swapped words.** An engine that ignored bit order or word order would release these copies instead of asking for a retry.
- **Non-critical words between critical ones.** A design that folded them in would report false mismatches.
- **Third copy agreeing with the first, the second, or neither.** Swapping the two stored cores names the wrong culprit. Forgetting the neither case releases corrupted results.
- **Refused allocation followed by that task's copies, a completion for an unknown task, and slot reuse after release.** A design that leaks slots, or matches stale IDs, stalls or produces phantom results.

// File: rtl/fpchk_pkg.sv
package fpchk_pkg;
    localparam int FP_W   = 16;
    localparam int WORD_W = 32;
    localparam int TID_W  = 4;
    localparam int CORE_W = 2;
    localparam logic [FP_W-1:0] CRC_POLY = 16'h1021;
    localparam logic [FP_W-1:0] CRC_SEED = 16'hFFFF;

    typedef enum logic [2:0] {
        SL_FREE, SL_WAIT0, SL_WAIT1, SL_PAIR, SL_RETRY, SL_TRIO
    } slot_phase_e;

    typedef struct packed {
        logic [FP_W-1:0]   fp;
        logic              par;
        logic [CORE_W-1:0] core;
    } copy_t;

    typedef struct packed {
        slot_phase_e      phase;
        logic [TID_W-1:0] tid;
        copy_t            a;
        copy_t            b;
        copy_t            c;
    } slot_t;

    typedef enum logic [1:0] {UPD_NONE, UPD_FREE, UPD_RETRY} upd_e;

    function automatic logic [FP_W-1:0] crc_fold(input logic [FP_W-1:0] cur,
                                                 input logic [WORD_W-1:0] w);
        logic [FP_W-1:0] r;
        logic fb;
        r = cur;
        for (int i = WORD_W-1; i >= 0; i--) begin
            fb = r[FP_W-1] ^ w[i];
            r  = {r[FP_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction
endpackage

// File: rtl/fp_crc_engine.sv
module fp_crc_engine
    import fpchk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fp_en,
    input  logic [WORD_W-1:0] word,
    input  logic              clear,
    output logic [FP_W-1:0]   fp
);
    logic [FP_W-1:0] crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      crc_q <= CRC_SEED;
        else if (clear)  crc_q <= CRC_SEED;
        else if (fp_en)  crc_q <= crc_fold(crc_q, word);
    end

    assign fp = crc_q;

    // R2: without enable or capture, the running fingerprint holds
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fp_en && !clear) |=> $stable(crc_q));
endmodule

// File: rtl/fp_slot_store.sv
module fp_slot_store
    import fpchk_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [TID_W-1:0]  alloc_tid,
    output logic              alloc_full,
    input  logic              done_valid,
    input  logic [CORE_W-1:0] done_core,
    input  logic [TID_W-1:0]  done_tid,
    input  logic [FP_W-1:0]   done_fp,
    input  upd_e              upd_kind,
    input  logic [IDX_W-1:0]  upd_idx,
    output slot_t             slots [ENTRIES],
    output logic [ENTRIES-1:0] pend
);
    logic             has_free, hit;
    logic [IDX_W-1:0] free_idx, hit_idx;
    copy_t            cpy;

    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        hit      = 1'b0;
        hit_idx  = '0;
        for (int i = ENTRIES-1; i >= 0; i--) begin
            if (slots[i].phase == SL_FREE) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
            if ((slots[i].phase == SL_WAIT0 || slots[i].phase == SL_WAIT1 ||
                 slots[i].phase == SL_RETRY) && slots[i].tid == done_tid) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
            pend[i] = (slots[i].phase == SL_PAIR) || (slots[i].phase == SL_TRIO);
        end
        cpy.fp   = done_fp;
        cpy.par  = ^done_fp;
        cpy.core = done_core;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) slots[i] <= '0;
            alloc_full <= 1'b0;
        end else begin
            alloc_full <= alloc_valid && !has_free;
            if (alloc_valid && has_free) begin
                slots[free_idx].phase <= SL_WAIT0;
                slots[free_idx].tid   <= alloc_tid;
            end
            if (done_valid && hit) begin
                case (slots[hit_idx].phase)
                    SL_WAIT0: begin
                        slots[hit_idx].a     <= cpy;
                        slots[hit_idx].phase <= SL_WAIT1;
                    end
                    SL_WAIT1: begin
                        slots[hit_idx].b     <= cpy;
                        slots[hit_idx].phase <= SL_PAIR;
                    end
                    SL_RETRY: begin
                        slots[hit_idx].c     <= cpy;
                        slots[hit_idx].phase <= SL_TRIO;
                    end
                    default: ;
                endcase
            end
            if (upd_kind == UPD_FREE)       slots[upd_idx].phase <= SL_FREE;
            else if (upd_kind == UPD_RETRY) slots[upd_idx].phase <= SL_RETRY;
        end
    end

    // R3: a request with every slot taken is refused on the next cycle
    assert_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !has_free) |=> alloc_full);
    // R4: a completion for an unknown task leaves the pending set alone
    assert_orphan_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !hit && upd_kind == UPD_NONE) |=> $stable(pend));
endmodule

// File: rtl/fp_vote_fsm.sv
module fp_vote_fsm
    import fpchk_pkg::*;
#(
    parameter int ENTRIES = 4,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
)(
    input  logic               clk,
    input  logic               rst_n,
    input  slot_t              slots [ENTRIES],
    input  logic [ENTRIES-1:0] pend,
    output upd_e               upd_kind,
    output logic [IDX_W-1:0]   upd_idx,
    output logic               release_valid,
    output logic [TID_W-1:0]   release_tid,
    output logic               retry_valid,
    output logic [TID_W-1:0]   retry_tid,
    output logic               fault_valid,
    output logic [CORE_W-1:0]  fault_core,
    output logic               fatal_valid,
    output logic [TID_W-1:0]   fatal_tid
);
    typedef enum logic {J_IDLE, J_JUDGE} jstate_e;
    typedef enum logic [2:0] {V_RELEASE, V_RETRY, V_FIX_A, V_FIX_B, V_FATAL} verdict_e;

    jstate_e          state_q, state_d;
    logic [IDX_W-1:0] sel_q, pick_idx;
    logic             any_pend;
    slot_t            cur;
    logic             ok_a, ok_b, ok_c, eq_ab, ma, mb;
    verdict_e         verdict;

    always_comb begin
        any_pend = 1'b0;
        pick_idx = '0;
        for (int i = ENTRIES-1; i >= 0; i--) begin
            if (pend[i]) begin
                any_pend = 1'b1;
                pick_idx = IDX_W'(i);
            end
        end
        cur   = slots[sel_q];
        ok_a  = ~(^{cur.a.fp, cur.a.par});
        ok_b  = ~(^{cur.b.fp, cur.b.par});
        ok_c  = ~(^{cur.c.fp, cur.c.par});
        eq_ab = ok_a && ok_b && (cur.a.fp == cur.b.fp);
        ma    = ok_a && ok_c && (cur.a.fp == cur.c.fp);
        mb    = ok_b && ok_c && (cur.b.fp == cur.c.fp);
        if (cur.phase == SL_TRIO) begin
            if (ma && mb)  verdict = V_RELEASE;
            else if (ma)   verdict = V_FIX_B;
            else if (mb)   verdict = V_FIX_A;
            else           verdict = V_FATAL;
        end else begin
            verdict = eq_ab ? V_RELEASE : V_RETRY;
        end
    end

    always_comb begin
        state_d  = state_q;
        upd_kind = UPD_NONE;
        upd_idx  = sel_q;
        unique case (state_q)
            J_IDLE:  if (any_pend) state_d = J_JUDGE;
            J_JUDGE: begin
                state_d  = J_IDLE;
                upd_kind = (verdict == V_RETRY) ? UPD_RETRY : UPD_FREE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= J_IDLE;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == J_IDLE && any_pend) sel_q <= pick_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            release_valid <= 1'b0;
            retry_valid   <= 1'b0;
            fault_valid   <= 1'b0;
            fatal_valid   <= 1'b0;
            release_tid   <= '0;
            retry_tid     <= '0;
            fatal_tid     <= '0;
            fault_core    <= '0;
        end else begin
            release_valid <= 1'b0;
            retry_valid   <= 1'b0;
            fault_valid   <= 1'b0;
            fatal_valid   <= 1'b0;
            if (state_q == J_JUDGE) begin
                release_tid <= cur.tid;
                retry_tid   <= cur.tid;
                fatal_tid   <= cur.tid;
                unique case (verdict)
                    V_RELEASE: release_valid <= 1'b1;
                    V_RETRY:   retry_valid   <= 1'b1;
                    V_FIX_A: begin
                        release_valid <= 1'b1;
                        fault_valid   <= 1'b1;
                        fault_core    <= cur.a.core;
                    end
                    V_FIX_B: begin
                        release_valid <= 1'b1;
                        fault_valid   <= 1'b1;
                        fault_core    <= cur.b.core;
                    end
                    V_FATAL:   fatal_valid   <= 1'b1;
                endcase
            end
        end
    end

    // R9: judging lasts one cycle and results are single pulses
    assert_judge_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == J_JUDGE) |=> (state_q == J_IDLE));
    assert_release_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        release_valid |=> !release_valid);
    // R5: only a slot holding a complete set is ever judged
    assert_judge_on_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == J_JUDGE) |-> pend[sel_q]);
    // R6: a retry request never releases
    assert_retry_no_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        retry_valid |-> !release_valid);
    // R7: a located fault always comes with a release
    assert_fault_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> release_valid);
    // R8: a failed vote neither releases nor names a core
    assert_fatal_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_valid |-> (!release_valid && !fault_valid));
endmodule

// File: rtl/fp_redundancy_checker.sv
module fp_redundancy_checker
    import fpchk_pkg::*;
#(
    parameter int NUM_CORES = 3,
    parameter int ENTRIES   = 4,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
)(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CORES-1:0]          fp_en,
    input  logic [NUM_CORES*WORD_W-1:0]   evt_word,
    input  logic                          done_valid,
    input  logic [CORE_W-1:0]             done_core,
    input  logic [TID_W-1:0]              done_tid,
    input  logic                          alloc_valid,
    input  logic [TID_W-1:0]              alloc_tid,
    output logic                          alloc_full,
    output logic                          release_valid,
    output logic [TID_W-1:0]              release_tid,
    output logic                          retry_valid,
    output logic [TID_W-1:0]              retry_tid,
    output logic                          fault_valid,
    output logic [CORE_W-1:0]             fault_core,
    output logic                          fatal_valid,
    output logic [TID_W-1:0]              fatal_tid
);
    logic [FP_W-1:0]    fp_all [NUM_CORES];
    logic [FP_W-1:0]    done_fp;
    logic               done_ok;
    slot_t              slots [ENTRIES];
    logic [ENTRIES-1:0] pend;
    upd_e               upd_kind;
    logic [IDX_W-1:0]   upd_idx;

    assign done_ok = done_valid && (int'(done_core) < NUM_CORES);

    for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_core
        fp_crc_engine u_crc (
            .clk   (clk),
            .rst_n (rst_n),
            .fp_en (fp_en[gi]),
            .word  (evt_word[gi*WORD_W +: WORD_W]),
            .clear (done_ok && (int'(done_core) == gi)),
            .fp    (fp_all[gi])
        );
    end

    always_comb begin
        done_fp = '0;
        for (int i = 0; i < NUM_CORES; i++)
            if (int'(done_core) == i) done_fp = fp_all[i];
    end

    fp_slot_store #(.ENTRIES(ENTRIES)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_valid (alloc_valid),
        .alloc_tid   (alloc_tid),
        .alloc_full  (alloc_full),
        .done_valid  (done_ok),
        .done_core   (done_core),
        .done_tid    (done_tid),
        .done_fp     (done_fp),
        .upd_kind    (upd_kind),
        .upd_idx     (upd_idx),
        .slots       (slots),
        .pend        (pend)
    );

    fp_vote_fsm #(.ENTRIES(ENTRIES)) u_judge (
        .clk           (clk),
        .rst_n         (rst_n),
        .slots         (slots),
        .pend          (pend),
        .upd_kind      (upd_kind),
        .upd_idx       (upd_idx),
        .release_valid (release_valid),
        .release_tid   (release_tid),
        .retry_valid   (retry_valid),
        .retry_tid     (retry_tid),
        .fault_valid   (fault_valid),
        .fault_core    (fault_core),
        .fatal_valid   (fatal_valid),
        .fatal_tid     (fatal_tid)
    );
endmodule

// File: tb/fp_redundancy_checker_test.sv
module fp_redundancy_checker_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  fp_en = '0;
    logic [95:0] evt_word = '0;
    logic        done_valid = 1'b0;
    logic [1:0]  done_core = '0;
    logic [3:0]  done_tid = '0;
    logic        alloc_valid = 1'b0;
    logic [3:0]  alloc_tid = '0;
    logic        alloc_full, release_valid, retry_valid, fault_valid, fatal_valid;
    logic [3:0]  release_tid, retry_tid, fatal_tid;
    logic [1:0]  fault_core;

    fp_redundancy_checker uut (.*);

    always #(CLK_P/2) clk = ~clk;

    int n_tests = 0, n_fail = 0;
    int rel_n, retry_n, fault_n, fatal_n, dbl_n;
    int rel_tid, retry_tid_s, fault_core_s, fatal_tid_s;
    bit prev_rel = 0;
    logic [31:0] wa [16], wb [16], wc [16];

    always @(negedge clk) if (rst_n) begin
        if (release_valid) begin rel_n++; rel_tid = release_tid; if (prev_rel) dbl_n++; end
        if (retry_valid) begin retry_n++; retry_tid_s = retry_tid; end
        if (fault_valid) begin fault_n++; fault_core_s = fault_core; end
        if (fatal_valid) begin fatal_n++; fatal_tid_s = fatal_tid; end
        prev_rel = release_valid;
    end

    task automatic tick; @(posedge clk); #2; endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr; rel_n = 0; retry_n = 0; fault_n = 0; fatal_n = 0; dbl_n = 0; endtask

    function automatic logic [31:0] getw(input int src, input int i);
        if (src == 0) return wa[i];
        if (src == 1) return wb[i];
        return wc[i];
    endfunction

    function automatic logic [15:0] ref_crc(input int src, input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            logic [31:0] w = getw(src, i);
            for (int b = 31; b >= 0; b--)
                c = (c << 1) ^ ((c[15] ^ w[b]) ? 16'h1021 : 16'h0000);
        end
        return c;
    endfunction

    task automatic prep(input int n, input int kb, input int kc);
        for (int i = 0; i < 16; i++) wa[i] = $urandom;
        for (int i = 0; i < 16; i++) wb[i] = wa[i];
        if (kb == 1) begin
            int k = $urandom % n;
            wb[k][$urandom % 32] ^= 1'b1;
        end else if (kb == 2 && n >= 2) begin
            wb[0] = wa[1]; wb[1] = wa[0];
        end
        for (int i = 0; i < 16; i++) wc[i] = (kc == 0) ? wa[i] : (kc == 1) ? wb[i] : $urandom;
    endtask

    task automatic do_alloc(input int tid, input bit exp_full, input string req);
        alloc_valid = 1'b1; alloc_tid = 4'(tid);
        tick;
        alloc_valid = 1'b0;
        chk(alloc_full == exp_full, req, alloc_full, exp_full);
    endtask

    task automatic run_copy(input int core, input int tid, input int src, input int n, input bit noise);
        for (int i = 0; i < n; i++) begin
            if (noise && ($urandom % 2 == 1)) begin
                fp_en[core] = 1'b0; evt_word[core*32 +: 32] = $urandom;
                tick;
            end
            fp_en[core] = 1'b1; evt_word[core*32 +: 32] = getw(src, i);
            tick;
        end
        fp_en[core] = 1'b0;
        done_valid = 1'b1; done_core = 2'(core); done_tid = 4'(tid);
        tick;
        done_valid = 1'b0;
    endtask

    task automatic wait_res; for (int i = 0; i < 6; i++) tick; endtask

    task automatic scenario(input int tid, input int ca, input int cb, input int cc,
                            input int n, input bit noise, input bit alloc_it);
        logic [15:0] fa, fb, fc;
        clr;
        if (alloc_it) do_alloc(tid, 1'b0, "R3 accept");
        run_copy(ca, tid, 0, n, 1'b0);
        run_copy(cb, tid, 1, n, noise);
        wait_res;
        fa = ref_crc(0, n); fb = ref_crc(1, n);
        if (fa == fb) begin
            chk(rel_n == 1 && rel_tid == tid, "R5/R1 release on match", rel_tid, tid);
            chk(retry_n == 0, "R5 no retry on match", retry_n, 0);
        end else begin
            chk(retry_n == 1 && retry_tid_s == tid, "R6/R1 retry on mismatch", retry_tid_s, tid);
            chk(rel_n == 0, "R6 no release on mismatch", rel_n, 0);
            run_copy(cc, tid, 2, n, 1'b0);
            wait_res;
            fc = ref_crc(2, n);
            if (fc == fa) begin
                chk(fault_n == 1 && fault_core_s == cb, "R7 fault names second core", fault_core_s, cb);
                chk(rel_n == 1 && rel_tid == tid, "R7 release after vote", rel_n, 1);
            end else if (fc == fb) begin
                chk(fault_n == 1 && fault_core_s == ca, "R7 fault names first core", fault_core_s, ca);
                chk(rel_n == 1 && rel_tid == tid, "R7 release after vote", rel_n, 1);
            end else begin
                chk(fatal_n == 1 && fatal_tid_s == tid, "R8 fatal on no majority", fatal_tid_s, tid);
                chk(rel_n == 0 && fault_n == 0, "R8 no release or fault", rel_n + fault_n, 0);
            end
        end
        chk(dbl_n == 0, "R9 single-cycle pulse", dbl_n, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog R9 actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) tick;
        rst_n = 1'b1;
        tick;
        chk(!release_valid && !retry_valid && !fault_valid && !fatal_valid && !alloc_full,
            "R9 reset outputs low", release_valid, 0);

        prep(8, 0, 0); scenario(1, 0, 1, 2, 8, 1'b0, 1'b1);           // R1 match
        prep(8, 0, 0); scenario(2, 1, 0, 2, 8, 1'b1, 1'b1);           // R2 noise ignored
        prep(6, 1, 0); scenario(3, 0, 2, 1, 6, 1'b0, 1'b1);           // R7 third = first
        prep(6, 2, 1); scenario(4, 2, 1, 0, 6, 1'b0, 1'b1);           // R1 swap, R7 third = second
        prep(5, 1, 2); scenario(5, 1, 2, 0, 5, 1'b0, 1'b1);           // R8 fatal

        clr; prep(4, 0, 0);
        run_copy(0, 12, 0, 4, 1'b0); wait_res;                        // R4 orphan
        chk(rel_n + retry_n + fault_n + fatal_n == 0, "R4 unknown task ignored",
            rel_n + retry_n + fault_n + fatal_n, 0);

        for (int t = 1; t <= 4; t++) do_alloc(t, 1'b0, "R3 accept while free");
        do_alloc(9, 1'b1, "R3 refuse when full");
        clr; prep(3, 0, 0);
        run_copy(0, 9, 0, 3, 1'b0); run_copy(1, 9, 1, 3, 1'b0); wait_res;
        chk(rel_n + retry_n == 0, "R3 refused task ignored", rel_n + retry_n, 0);
        for (int t = 1; t <= 4; t++) begin
            prep(3, 0, 0); scenario(t, 2, 0, 1, 3, 1'b0, 1'b0);
        end
        do_alloc(9, 1'b0, "R5 slot reusable after release");
        prep(2, 0, 0); scenario(9, 0, 1, 2, 2, 1'b0, 1'b0);

        for (int it = 0; it < 24; it++) begin
            int ca = $urandom % 3;
            int cb = (ca + 1 + ($urandom % 2)) % 3;
            int n  = 1 + ($urandom % 12);
            prep(n, $urandom % 3, $urandom % 3);
            scenario($urandom % 16, ca, cb, 3 - ca - cb, n, 1'($urandom % 2), 1'b1);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule